// File: doc/BRIEF.md
# LCD Frame and Blink Clock Divider

This block turns a 32768 Hz timebase into the slow square waves an LCD segment driver needs. The timebase arrives as a one-cycle enable, `base_tick`, on the fast system clock. A single 15-bit counter advances on each enable. The block takes two frame-rate clocks and three blink-rate clocks from chosen bits of that counter, and registers them so they change on one system clock edge with no glitches.

The two frame-rate outputs take different counter bits depending on the drive mode. Half-duty drive needs frame clocks twice as slow as static drive. The mode input can change at any time, and the counter keeps running through the change.

The block also holds an edge detector. It counts rising edges on `cnt_in`, sampled by the system clock, and raises a flag on the sixteenth edge. The flag stays high until reset.

Top module: `lcd_clkdiv_top`

## Requirements
- R1: A synchronous active-high reset clears the tap counter and the edge counter. All five clock outputs and `cnt_flag` read 0 on the first cycle after reset is released.
- R2: The tap counter advances by exactly one on each clock edge where `base_tick` is 1, and holds its value otherwise. An idle `base_tick` leaves every clock output unchanged.
- R3: With `half_duty` = 1, `frame_main` is the tick rate divided by 256 (counter bit 7) and `frame_aux` is the tick rate divided by 128 (counter bit 6).
- R4: With `half_duty` = 0 (static drive), `frame_main` is the tick rate divided by 128 (counter bit 6) and `frame_aux` is the tick rate divided by 64 (counter bit 5).
- R5: `blink_4hz`, `blink_2hz` and `blink_1hz` are the tick rate divided by 8192, 16384 and 32768, taken from counter bits 12, 13 and 14. All outputs are 50% duty square waves and are registered, so they reflect the counter value one clock after it is reached.
- R6: Changing `half_duty` reselects the frame taps on the next clock without clearing or disturbing the counter.
- R7: The counter wraps from 32767 to 0 after 32768 ticks, and all outputs return to 0 at that point.
- R8: A rising edge of `cnt_in` is a clock sample of 1 that follows a sample of 0. A level held high counts once. `cnt_flag` rises on the clock edge at which the sixteenth such edge is sampled, and never earlier.
- R9: Once `cnt_flag` is high it stays high, and further `cnt_in` edges have no effect until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| base_tick | input | 1 | One-cycle enable at the 32768 Hz timebase rate |
| half_duty | input | 1 | Drive mode: 1 selects half-duty taps, 0 selects static taps |
| cnt_in | input | 1 | Input whose rising edges are counted |
| frame_main | output | 1 | Primary LCD frame clock |
| frame_aux | output | 1 | Secondary LCD frame clock, twice the primary rate |
| blink_4hz | output | 1 | Timebase divided by 8192 |
| blink_2hz | output | 1 | Timebase divided by 16384 |
| blink_1hz | output | 1 | Timebase divided by 32768 |
| cnt_flag | output | 1 | Goes high on the sixteenth counted edge and stays high |

## Verification
The assertions assume that `base_tick` and `cnt_in` are synchronous to `clk`. They also assume that `cnt_in` is low during reset, so that no edge is counted on the first cycle after it. The stimulus changes every input only on the falling clock edge and holds `cnt_in` low through each reset. It drives `base_tick` high for runs of consecutive cycles, which is the densest legal pattern, and the counter checks still hold under it. The edge tests include a long high level on `cnt_in`, which must count as one edge.

// File: rtl/lcd_clkdiv_pkg.sv
package lcd_clkdiv_pkg;

    localparam int CNT_W       = 15;
    localparam int EDGE_TARGET = 16;

    // counter bit positions for each division ratio
    localparam int TAP_DIV64    = 5;
    localparam int TAP_DIV128   = 6;
    localparam int TAP_DIV256   = 7;
    localparam int TAP_DIV8192  = 12;
    localparam int TAP_DIV16384 = 13;
    localparam int TAP_DIV32768 = 14;

    typedef enum logic {
        DRIVE_STATIC = 1'b0,
        DRIVE_HALF   = 1'b1
    } drive_mode_e;

    typedef struct packed {
        logic frame_main;
        logic frame_aux;
        logic blink_fast;
        logic blink_mid;
        logic blink_slow;
    } clk_taps_t;

    function automatic int main_tap(drive_mode_e m);
        return (m == DRIVE_HALF) ? TAP_DIV256 : TAP_DIV128;
    endfunction

    function automatic int aux_tap(drive_mode_e m);
        return (m == DRIVE_HALF) ? TAP_DIV128 : TAP_DIV64;
    endfunction

endpackage

// File: rtl/lcd_tick_counter.sv
module lcd_tick_counter #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (tick)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/lcd_tap_select.sv
module lcd_tap_select
    import lcd_clkdiv_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  count,
    input  drive_mode_e   mode,
    output clk_taps_t     taps
);
    clk_taps_t next_taps;

    always_comb begin
        next_taps.frame_main = count[main_tap(mode)];
        next_taps.frame_aux  = count[aux_tap(mode)];
        next_taps.blink_fast = count[TAP_DIV8192];
        next_taps.blink_mid  = count[TAP_DIV16384];
        next_taps.blink_slow = count[TAP_DIV32768];
    end

    always_ff @(posedge clk) begin
        if (rst)
            taps <= '0;
        else
            taps <= next_taps;
    end
endmodule

// File: rtl/lcd_edge_counter.sv
module lcd_edge_counter #(
    parameter int TARGET = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic sig_in,
    output logic flag
);
    localparam int EW = (TARGET > 1) ? $clog2(TARGET) : 1;
    localparam logic [EW-1:0] LAST = EW'(TARGET - 1);

    logic          prev_q;
    logic [EW-1:0] seen_q;
    logic          rise;

    assign rise = sig_in & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            seen_q <= '0;
            flag   <= 1'b0;
        end else begin
            prev_q <= sig_in;
            if (rise && !flag) begin
                if (seen_q == LAST)
                    flag <= 1'b1;
                else
                    seen_q <= seen_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/lcd_clkdiv_top.sv
module lcd_clkdiv_top
    import lcd_clkdiv_pkg::*;
#(
    parameter int CNT_BITS   = CNT_W,
    parameter int EDGE_COUNT = EDGE_TARGET
) (
    input  logic clk,
    input  logic rst,
    input  logic base_tick,
    input  logic half_duty,
    input  logic cnt_in,
    output logic frame_main,
    output logic frame_aux,
    output logic blink_4hz,
    output logic blink_2hz,
    output logic blink_1hz,
    output logic cnt_flag
);
    logic [CNT_BITS-1:0] cnt_q;
    clk_taps_t           taps;
    drive_mode_e         mode;

    assign mode = drive_mode_e'(half_duty);

    lcd_tick_counter #(.W(CNT_BITS)) u_counter (
        .clk   (clk),
        .rst   (rst),
        .tick  (base_tick),
        .count (cnt_q)
    );

    lcd_tap_select #(.W(CNT_BITS)) u_taps (
        .clk   (clk),
        .rst   (rst),
        .count (cnt_q),
        .mode  (mode),
        .taps  (taps)
    );

    lcd_edge_counter #(.TARGET(EDGE_COUNT)) u_edges (
        .clk    (clk),
        .rst    (rst),
        .sig_in (cnt_in),
        .flag   (cnt_flag)
    );

    assign frame_main = taps.frame_main;
    assign frame_aux  = taps.frame_aux;
    assign blink_4hz  = taps.blink_fast;
    assign blink_2hz  = taps.blink_mid;
    assign blink_1hz  = taps.blink_slow;
endmodule

// File: rtl/lcd_clkdiv_chk.sv
module lcd_clkdiv_chk #(
    parameter int CNT_BITS = 15
) (
    input logic                clk,
    input logic                rst,
    input logic                base_tick,
    input logic [CNT_BITS-1:0] cnt,
    input logic                cnt_in,
    input logic                frame_main,
    input logic                frame_aux,
    input logic                blink_4hz,
    input logic                blink_2hz,
    input logic                blink_1hz,
    input logic                cnt_flag
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> ({frame_main, frame_aux, blink_4hz, blink_2hz, blink_1hz, cnt_flag} == 6'b0));

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        base_tick |=> (cnt == CNT_BITS'($past(cnt) + 1'b1)));

    // R2
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !base_tick |=> $stable(cnt));

    // R5
    blink_ripple_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(blink_1hz) |-> $fell(blink_2hz));

    // R8
    flag_needs_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cnt_flag) |-> ($past(cnt_in) && !$past(cnt_in, 2)));

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_flag |=> cnt_flag);
endmodule

bind lcd_clkdiv_top lcd_clkdiv_chk #(.CNT_BITS(CNT_BITS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .base_tick  (base_tick),
    .cnt        (cnt_q),
    .cnt_in     (cnt_in),
    .frame_main (frame_main),
    .frame_aux  (frame_aux),
    .blink_4hz  (blink_4hz),
    .blink_2hz  (blink_2hz),
    .blink_1hz  (blink_1hz),
    .cnt_flag   (cnt_flag)
);

// File: tb/tb_lcd_clkdiv_top.sv
module tb_lcd_clkdiv_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic base_tick = 1'b0;
    logic half_duty = 1'b0;
    logic cnt_in = 1'b0;
    logic frame_main, frame_aux, blink_4hz, blink_2hz, blink_1hz, cnt_flag;

    int n_checks = 0;
    int n_fail = 0;
    int cur = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lcd_clkdiv_top dut (
        .clk(clk), .rst(rst), .base_tick(base_tick), .half_duty(half_duty),
        .cnt_in(cnt_in), .frame_main(frame_main), .frame_aux(frame_aux),
        .blink_4hz(blink_4hz), .blink_2hz(blink_2hz), .blink_1hz(blink_1hz),
        .cnt_flag(cnt_flag)
    );

    // {target count[15:0], half_duty, expected {main, aux, 4hz, 2hz, 1hz}}
    localparam int NV = 10;
    localparam logic [21:0] VEC [NV] = '{
        {16'd32,    1'b0, 5'b01000},  // R4
        {16'd32,    1'b1, 5'b00000},  // R6 R3
        {16'd64,    1'b1, 5'b01000},  // R3
        {16'd64,    1'b0, 5'b10000},  // R6 R4
        {16'd192,   1'b1, 5'b11000},  // R3
        {16'd4096,  1'b1, 5'b00100},  // R5
        {16'd12288, 1'b0, 5'b00110},  // R5
        {16'd24800, 1'b0, 5'b11011},  // R4 R5
        {16'd32767, 1'b1, 5'b11111},  // R3 R5
        {16'd32768, 1'b1, 5'b00000}   // R7
    };

    function automatic logic [4:0] outs();
        return {frame_main, frame_aux, blink_4hz, blink_2hz, blink_1hz};
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic run_ticks(int n);
        if (n > 0) begin
            @(negedge clk) base_tick = 1'b1;
            repeat (n) @(negedge clk);
            base_tick = 1'b0;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_cnt(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) cnt_in = 1'b1;
            @(negedge clk) cnt_in = 1'b0;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        cur = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", {2'b0, outs(), cnt_flag}, 8'b0);

        for (int v = 0; v < NV; v++) begin
            half_duty = VEC[v][5];
            run_ticks(int'(VEC[v][21:6]) - cur);
            cur = int'(VEC[v][21:6]);
            check($sformatf("R3/R4/R5/R6/R7 vec%0d", v), {3'b0, outs()}, {3'b0, VEC[v][4:0]});
        end

        // R2: counter holds while base_tick idle
        run_ticks(64);
        half_duty = 1'b0;
        repeat (300) @(negedge clk);
        check("R2 hold", {3'b0, outs()}, 8'b00010000);
        run_ticks(1);
        check("R2 single step", {3'b0, outs()}, 8'b00010000);

        // R1: reset mid-run restarts the counter from zero
        run_ticks(135);
        half_duty = 1'b1;
        @(negedge clk);
        check("R3 pre-reset", {3'b0, outs()}, 8'b00011000);
        do_reset();
        check("R1 mid-run", {2'b0, outs(), cnt_flag}, 8'b0);
        half_duty = 1'b0;
        run_ticks(64);
        check("R1 restart", {3'b0, outs()}, 8'b00010000);

        // R8: a held level counts once
        @(negedge clk) cnt_in = 1'b1;
        repeat (20) @(negedge clk);
        cnt_in = 1'b0;
        pulse_cnt(14);
        check("R8 fifteen edges", {7'b0, cnt_flag}, 8'd0);
        @(negedge clk) cnt_in = 1'b1;
        @(negedge clk);
        check("R8 sixteenth edge", {7'b0, cnt_flag}, 8'd1);
        cnt_in = 1'b0;
        pulse_cnt(5);
        check("R9 sticky", {7'b0, cnt_flag}, 8'd1);
        do_reset();
        check("R9 cleared by reset R1", {7'b0, cnt_flag}, 8'd0);
        pulse_cnt(16);
        check("R8 sixteen pulses", {7'b0, cnt_flag}, 8'd1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule